// File: doc/BRIEF.md
# DMA Transfer Request Generator

This block is the request front end of a four-channel DMA controller. For each channel it decides, every clock, whether a transfer request is pending and tells the transfer engine which address mode to use. The engine answers each granted request with a one-cycle acknowledge. Bus cycles, address counters, arbitration between channels and register access all sit outside this block.

Each channel carries a 4-bit mode code that picks where its request comes from. Auto mode raises the request internally, which suits memory-to-memory copies and peripherals that cannot ask for service. External mode takes an active-low request pin through a two-flop synchronizer and detects either a falling edge or a held-low level. Peripheral mode follows one of several peripheral request lines, picked by a per-channel select field. Every source is gated by the channel enable, a controller-wide master enable, the channel's transfer-end flag and two global flags, address error and NMI. When either global flag is set, all requests drop at once.

Top module: `dma_req_gen`

## Requirements
- R1: `req_o[c]` is 1 only while `ch_en_i[c]`=1, `master_en_i`=1, `xfer_end_i[c]`=0, `addr_err_i`=0 and `nmi_i`=0.
- R2: Mode code 4'b0100 (auto) sets `req_o[c]` at the first rising edge where the R1 conditions hold, with no input pin involved. The request stays high for as long as the conditions hold.
- R3: In level mode (`ext_edge_i[c]`=0), an external request on `ext_req_ni[c]` is seen through two synchronizer flops. After the pin goes low, `req_o[c]` rises after the third rising edge.
- R4: In edge mode (`ext_edge_i[c]`=1), one falling edge on the pin gives one request, visible after the third rising edge. Holding the pin low after the acknowledge does not raise a new request.
- R5: External mode codes are 4'b0000, 4'b0010 and 4'b0011. 4'b0000 gives dual address (`single_o`=0). 4'b0010 gives single address from memory to the acknowledged device (`single_o`=1, `dir_o`=0). 4'b0011 gives single address from the device to memory (`single_o`=1, `dir_o`=1).
- R6: On channels 2 and 3, external mode codes are invalid. These channels never raise a request and drive `single_o`=0 and `dir_o`=0.
- R7: Mode code 4'b1000 (peripheral) takes its request from `periph_req_i[s]`. Here `s` is the channel's field `periph_sel_i[c*3 +: 3]`. The other peripheral lines have no effect.
- R8: When `addr_err_i` or `nmi_i` is set, all `req_o` bits drop in the same cycle. Pending requests are discarded, so they are not restored when the flag clears.
- R9: Once raised, `req_o[c]` stays high until `ack_i[c]` is 1 on a rising edge. In the cycle after that it is 0, unless its source is still requesting.
- R10: Any mode code not listed in R2, R5 or R7 raises no request.
- R11: While `rst_ni` is low, all `req_o` bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ch_en_i | input | 4 | Per-channel enable |
| master_en_i | input | 1 | Controller-wide enable |
| xfer_end_i | input | 4 | Per-channel transfer-end flag |
| addr_err_i | input | 1 | Global address-error flag |
| nmi_i | input | 1 | Global NMI flag |
| mode_i | input | 16 | Mode code, 4 bits per channel, channel c at [4c+3:4c] |
| ext_edge_i | input | 2 | External detect select per external channel: 1 edge, 0 level |
| ext_req_ni | input | 2 | Active-low external request pins, channels 0 and 1 |
| periph_req_i | input | 8 | Peripheral request lines |
| periph_sel_i | input | 12 | Peripheral select, 3 bits per channel |
| ack_i | input | 4 | One-cycle acknowledge from the transfer engine |
| req_o | output | 4 | Request strobe per channel |
| single_o | output | 4 | 1 when the channel runs single address |
| dir_o | output | 4 | Single-address direction: 1 device to memory |

## Verification
The bench targets the synchronizer latency in both detect styles. A design with one flop too few or too many would raise the request a cycle early or late. In edge mode, after an acknowledge, the pin is held low. A design that treats edge mode as level would raise the request again at once. The NMI and address-error flags are raised while a request is pending, and the output is checked in that same cycle. A design that clears the request only through its register would still show it for one cycle. A design that kept the pending state would bring the request back when the flag clears. External mode codes on channels 2 and 3, unlisted codes and unselected peripheral lines are each shown to leave the request low. Such a fault would show up as a request on a channel that has no pin.

// File: rtl/dma_req_pkg.sv
package dma_req_pkg;
  localparam int unsigned MODE_W = 4;

  localparam logic [MODE_W-1:0] MODE_EXT_DUAL = 4'b0000;
  localparam logic [MODE_W-1:0] MODE_EXT_M2D  = 4'b0010;
  localparam logic [MODE_W-1:0] MODE_EXT_D2M  = 4'b0011;
  localparam logic [MODE_W-1:0] MODE_AUTO     = 4'b0100;
  localparam logic [MODE_W-1:0] MODE_PERI     = 4'b1000;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_AUTO = 2'd1,
    SRC_EXT  = 2'd2,
    SRC_PERI = 2'd3
  } src_e;
endpackage

// File: rtl/dma_req_sync.sv
module dma_req_sync #(
  parameter int unsigned NUM = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NUM-1:0] req_ni,
  input  logic [NUM-1:0] edge_mode_i,
  output logic [NUM-1:0] trig_o
);
  for (genvar i = 0; i < NUM; i++) begin : g_pin
    logic s1_q, s2_q, s3_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= 1'b1;
        s2_q <= 1'b1;
        s3_q <= 1'b1;
      end else begin
        s1_q <= req_ni[i];
        s2_q <= s1_q;
        s3_q <= s2_q;
      end
    end

    // edge: high-to-low on synchronized pin; level: synchronized low
    assign trig_o[i] = edge_mode_i[i] ? (s3_q & ~s2_q) : ~s2_q;
  end
endmodule

// File: rtl/dma_req_decode.sv
module dma_req_decode
  import dma_req_pkg::*;
#(
  parameter bit HAS_EXT = 1'b1
) (
  input  logic [MODE_W-1:0] mode_i,
  output src_e              src_o,
  output logic              single_o,
  output logic              dir_o
);
  always_comb begin
    src_o    = SRC_NONE;
    single_o = 1'b0;
    dir_o    = 1'b0;
    case (mode_i)
      MODE_AUTO: src_o = SRC_AUTO;
      MODE_PERI: src_o = SRC_PERI;
      MODE_EXT_DUAL: begin
        if (HAS_EXT) src_o = SRC_EXT;
      end
      MODE_EXT_M2D: begin
        if (HAS_EXT) begin
          src_o    = SRC_EXT;
          single_o = 1'b1;
        end
      end
      MODE_EXT_D2M: begin
        if (HAS_EXT) begin
          src_o    = SRC_EXT;
          single_o = 1'b1;
          dir_o    = 1'b1;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/dma_req_chan.sv
module dma_req_chan (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic gate_i,
  input  logic trig_i,
  input  logic ack_i,
  output logic req_o
);
  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= gate_i & (trig_i | (pend_q & ~ack_i));
  end

  // gate on the output so a flag drop kills the strobe in the same cycle
  assign req_o = pend_q & gate_i;
endmodule

// File: rtl/dma_req_gen.sv
module dma_req_gen
  import dma_req_pkg::*;
#(
  parameter int unsigned NUM_CH     = 4,
  parameter int unsigned NUM_EXT    = 2,
  parameter int unsigned NUM_PERIPH = 8,
  localparam int unsigned PSEL_W    = $clog2(NUM_PERIPH)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NUM_CH-1:0]          ch_en_i,
  input  logic                       master_en_i,
  input  logic [NUM_CH-1:0]          xfer_end_i,
  input  logic                       addr_err_i,
  input  logic                       nmi_i,
  input  logic [NUM_CH*MODE_W-1:0]   mode_i,
  input  logic [NUM_EXT-1:0]         ext_edge_i,
  input  logic [NUM_EXT-1:0]         ext_req_ni,
  input  logic [NUM_PERIPH-1:0]      periph_req_i,
  input  logic [NUM_CH*PSEL_W-1:0]   periph_sel_i,
  input  logic [NUM_CH-1:0]          ack_i,
  output logic [NUM_CH-1:0]          req_o,
  output logic [NUM_CH-1:0]          single_o,
  output logic [NUM_CH-1:0]          dir_o
);
  logic [NUM_EXT-1:0] ext_trig;
  logic               glob_ok;

  assign glob_ok = master_en_i & ~addr_err_i & ~nmi_i;

  dma_req_sync #(.NUM(NUM_EXT)) u_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_ni      (ext_req_ni),
    .edge_mode_i (ext_edge_i),
    .trig_o      (ext_trig)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    src_e              src;
    logic              ext_t;
    logic              trig;
    logic              gate;
    logic [PSEL_W-1:0] sel;

    if (c < NUM_EXT) begin : g_ext
      assign ext_t = ext_trig[c];
    end else begin : g_noext
      assign ext_t = 1'b0;
    end

    dma_req_decode #(.HAS_EXT(c < NUM_EXT)) u_dec (
      .mode_i   (mode_i[c*MODE_W +: MODE_W]),
      .src_o    (src),
      .single_o (single_o[c]),
      .dir_o    (dir_o[c])
    );

    assign sel  = periph_sel_i[c*PSEL_W +: PSEL_W];
    assign gate = glob_ok & ch_en_i[c] & ~xfer_end_i[c];

    always_comb begin
      case (src)
        SRC_AUTO: trig = 1'b1;
        SRC_EXT:  trig = ext_t;
        SRC_PERI: trig = periph_req_i[sel];
        default:  trig = 1'b0;
      endcase
    end

    dma_req_chan u_chan (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .gate_i (gate),
      .trig_i (trig),
      .ack_i  (ack_i[c]),
      .req_o  (req_o[c])
    );
  end
endmodule

// File: rtl/dma_req_gen_chk.sv
module dma_req_gen_chk
  import dma_req_pkg::*;
#(
  parameter int unsigned NUM_CH  = 4,
  parameter int unsigned NUM_EXT = 2
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic [NUM_CH-1:0]        ch_en_i,
  input logic                     master_en_i,
  input logic [NUM_CH-1:0]        xfer_end_i,
  input logic                     addr_err_i,
  input logic                     nmi_i,
  input logic [NUM_CH*MODE_W-1:0] mode_i,
  input logic [NUM_CH-1:0]        ack_i,
  input logic [NUM_CH-1:0]        req_o,
  input logic [NUM_CH-1:0]        single_o,
  input logic [NUM_CH-1:0]        dir_o
);
  a_r11_reset_quiet: assert property (@(posedge clk_i) !rst_ni |-> req_o == '0);

  a_r8_flag_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_err_i || nmi_i) |-> req_o == '0);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_c
    logic              ok;
    logic [MODE_W-1:0] m;
    logic              ext_code;
    assign ok = ch_en_i[c] & master_en_i & ~xfer_end_i[c] & ~addr_err_i & ~nmi_i;
    assign m  = mode_i[c*MODE_W +: MODE_W];
    assign ext_code = (m == MODE_EXT_DUAL) || (m == MODE_EXT_M2D) || (m == MODE_EXT_D2M);

    a_r1_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_o[c] |-> ok);

    a_r2_auto: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(rst_ni) && $past(ok && m == MODE_AUTO) && ok) |-> req_o[c]);

    a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_o[c] && !ack_i[c]) ##1 ok |-> req_o[c]);

    a_r10_unlisted: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!ext_code && m != MODE_AUTO && m != MODE_PERI) |-> !single_o[c] && !dir_o[c]);

    if (c < NUM_EXT) begin : g_ext
      a_r5_d2m: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (m == MODE_EXT_D2M) |-> single_o[c] && dir_o[c]);
      a_r5_dual: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (m == MODE_EXT_DUAL) |-> !single_o[c]);
    end else begin : g_noext
      a_r6_no_ext: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ext_code && $past(ext_code)) |-> !req_o[c] && !single_o[c]);
    end
  end
endmodule

bind dma_req_gen dma_req_gen_chk #(.NUM_CH(NUM_CH), .NUM_EXT(NUM_EXT)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ch_en_i     (ch_en_i),
  .master_en_i (master_en_i),
  .xfer_end_i  (xfer_end_i),
  .addr_err_i  (addr_err_i),
  .nmi_i       (nmi_i),
  .mode_i      (mode_i),
  .ack_i       (ack_i),
  .req_o       (req_o),
  .single_o    (single_o),
  .dir_o       (dir_o)
);

// File: tb/dma_req_gen_tb.sv
module dma_req_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  ch_en = 4'h0;
  logic        master_en = 1'b0;
  logic [3:0]  xfer_end = 4'h0;
  logic        addr_err = 1'b0;
  logic        nmi = 1'b0;
  logic [15:0] mode = 16'hFFFF;
  logic [1:0]  ext_edge = 2'b00;
  logic [1:0]  ext_req_n = 2'b11;
  logic [7:0]  periph_req = 8'h00;
  logic [11:0] periph_sel = 12'h000;
  logic [3:0]  ack = 4'h0;
  logic [3:0]  req, single, dir;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dma_req_gen u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ch_en_i(ch_en), .master_en_i(master_en),
    .xfer_end_i(xfer_end), .addr_err_i(addr_err), .nmi_i(nmi), .mode_i(mode),
    .ext_edge_i(ext_edge), .ext_req_ni(ext_req_n), .periph_req_i(periph_req),
    .periph_sel_i(periph_sel), .ack_i(ack), .req_o(req), .single_o(single), .dir_o(dir)
  );

  typedef struct packed {
    logic [3:0]  en;
    logic        men;
    logic [3:0]  xend;
    logic        err;
    logic        nm;
    logic [15:0] md;
    logic [3:0]  e_req;
    logic [3:0]  e_single;
    logic [3:0]  e_dir;
  } vec_t;

  // mode nibbles {ch3,ch2,ch1,ch0}
  localparam vec_t TBL [10] = '{
    '{4'hF, 1'b1, 4'h0, 1'b0, 1'b0, 16'h4444, 4'hF, 4'h0, 4'h0}, // R2 all auto
    '{4'hF, 1'b0, 4'h0, 1'b0, 1'b0, 16'h4444, 4'h0, 4'h0, 4'h0}, // R1 master off
    '{4'h5, 1'b1, 4'h0, 1'b0, 1'b0, 16'h4444, 4'h5, 4'h0, 4'h0}, // R1 ch enables
    '{4'hF, 1'b1, 4'h2, 1'b0, 1'b0, 16'h4444, 4'hD, 4'h0, 4'h0}, // R1 transfer end
    '{4'hF, 1'b1, 4'h0, 1'b1, 1'b0, 16'h4444, 4'h0, 4'h0, 4'h0}, // R1 addr err
    '{4'hF, 1'b1, 4'h0, 1'b0, 1'b1, 16'h4444, 4'h0, 4'h0, 4'h0}, // R1 nmi
    '{4'hF, 1'b1, 4'h0, 1'b0, 1'b0, 16'h0432, 4'h4, 4'h3, 4'h2}, // R5 R6
    '{4'hF, 1'b1, 4'h0, 1'b0, 1'b0, 16'hF340, 4'h2, 4'h0, 4'h0}, // R5 R6 R10
    '{4'hF, 1'b1, 4'h0, 1'b0, 1'b0, 16'h4461, 4'hC, 4'h0, 4'h0}, // R10 unlisted
    '{4'hF, 1'b1, 4'h0, 1'b0, 1'b0, 16'h4448, 4'hE, 4'h0, 4'h0}  // R7 idle line
  };

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic flush;
    master_en = 1'b0;
    step(1);
    master_en = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    step(2);
    chk("R11 reset", {28'd0, req}, 32'd0);
    rst_n = 1'b1;
    step(1);
    chk("R11 after reset", {28'd0, req}, 32'd0);

    for (int i = 0; i < 10; i++) begin
      flush();
      ch_en = TBL[i].en; master_en = TBL[i].men; xfer_end = TBL[i].xend;
      addr_err = TBL[i].err; nmi = TBL[i].nm; mode = TBL[i].md;
      step(1);
      chk($sformatf("R1 R2 vec%0d req", i), {28'd0, req}, {28'd0, TBL[i].e_req});
      chk($sformatf("R5 R6 vec%0d single", i), {28'd0, single}, {28'd0, TBL[i].e_single});
      chk($sformatf("R5 vec%0d dir", i), {28'd0, dir}, {28'd0, TBL[i].e_dir});
    end

    ch_en = 4'hF; xfer_end = 4'h0; addr_err = 1'b0; nmi = 1'b0;
    mode = 16'hFFF0;  // ch0 external dual, level
    flush();
    ext_req_n[0] = 1'b0;
    step(1); chk("R3 level edge1", {31'd0, req[0]}, 32'd0);
    step(1); chk("R3 level edge2", {31'd0, req[0]}, 32'd0);
    step(1); chk("R3 level edge3", {31'd0, req[0]}, 32'd1);
    chk("R5 dual", {31'd0, single[0]}, 32'd0);
    ext_req_n[0] = 1'b1;
    step(4); chk("R9 hold after pin release", {31'd0, req[0]}, 32'd1);
    ack[0] = 1'b1; step(1); ack[0] = 1'b0;
    chk("R9 drop after ack", {31'd0, req[0]}, 32'd0);

    mode = 16'hFF3F;  // ch1 external device-to-memory, edge
    ext_edge = 2'b10;
    flush();
    ext_req_n[1] = 1'b0;
    step(3); chk("R4 edge request", {31'd0, req[1]}, 32'd1);
    chk("R5 d2m single", {30'd0, single[1], dir[1]}, 32'd3);
    step(4); chk("R9 edge hold", {31'd0, req[1]}, 32'd1);
    ack[1] = 1'b1; step(1); ack[1] = 1'b0;
    chk("R9 edge ack", {31'd0, req[1]}, 32'd0);
    step(4); chk("R4 no retrigger held low", {31'd0, req[1]}, 32'd0);
    ext_req_n[1] = 1'b1; step(3);
    ext_req_n[1] = 1'b0; step(3);
    chk("R4 second edge", {31'd0, req[1]}, 32'd1);

    nmi = 1'b1; #1;
    chk("R8 nmi same cycle", {28'd0, req}, 32'd0);
    step(2); chk("R8 nmi held", {28'd0, req}, 32'd0);
    nmi = 1'b0;
    step(1); chk("R8 pending lost", {31'd0, req[1]}, 32'd0);
    step(3); chk("R8 stays lost", {31'd0, req[1]}, 32'd0);

    mode = 16'h4FFF;  // ch3 auto
    step(1); chk("R2 auto ch3", {31'd0, req[3]}, 32'd1);
    addr_err = 1'b1; #1;
    chk("R8 addr err same cycle", {28'd0, req}, 32'd0);
    step(1); chk("R8 addr err held", {28'd0, req}, 32'd0);
    addr_err = 1'b0;
    step(1); chk("R2 auto resumes", {31'd0, req[3]}, 32'd1);

    mode = 16'hF8FF;  // ch2 peripheral, select 5
    periph_sel = 12'b000_101_000_000;
    flush();
    periph_req = 8'b0000_1000;
    step(1); chk("R7 other line ignored", {31'd0, req[2]}, 32'd0);
    periph_req = 8'b0010_0000;
    step(1); chk("R7 selected line", {31'd0, req[2]}, 32'd1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule